// File: doc/BRIEF.md
# Voltage-ID Write Transaction Controller

This block runs one write to an external voltage regulator as a pair of 32-bit frames sent through a separate serial frame engine. It builds a command frame from the requested payload. When CRC generation is enabled, an 8-bit CRC is placed in the low byte. The block then waits a programmable gap and asks the engine for a status frame. The status reply carries the same status byte three times, followed by a CRC byte.

The reply is checked against its CRC when checking is enabled. The status byte is resolved bit by bit, either by 2-of-3 vote or by taking the first copy. A CRC mismatch starts a retry: the block waits a programmable retry gap and then repeats the whole command-plus-status pair, up to a programmed number of retries. When the retries are used up, a sticky error flag is raised and the last resolved status is kept. Both gaps are timed with a coarse tick of about 100 ns, after first waiting for one serial clock period.

Top module: `vid_write_ctrl`

## Requirements
- R1: With `crc_gen_en`=1, the command frame is `{payload[31:8], crc}`. Here `crc` is a CRC8 over `payload[31:8]`, taken MSB first from initial value 0x00. The polynomial is x^8 plus the terms enabled by `poly_mask` (bit k enables x^k), so 0xD5 gives x^8+x^7+x^6+x^4+x^2+1.
- R2: With `crc_gen_en`=0, the command frame equals the 32-bit payload unchanged.
- R3: A status reply holds three copies of the status byte in bits [31:24], [23:16] and [15:8], and its CRC in bits [7:0]. With `vote_en`=1, each status bit is the 2-of-3 majority of the three copies. With `vote_en`=0, the status is bits [31:24].
- R4: With `crc_chk_en`=1, a reply whose bits [7:0] differ from the R1 CRC of its bits [31:8] is an error. With `crc_chk_en`=0, no reply is an error.
- R5: A setting of N on `ifd_setting` (17 bits) places the status request after the command frame completes. The gap is at least one serial clock tick (N=0), or at least N-1 periods of `tick_100ns` (N>0). It is at most one serial clock period plus N tick periods plus a few cycles of overhead.
- R6: The gap from an erroneous status reply to the repeated command request follows the same rule, with `retry_delay` (16 bits) as N.
- R7: An error with fewer than `retry_limit` (0 to 31) retries used repeats the full command-plus-status pair. A good reply ends the transaction at once, so at most `retry_limit`+1 command frames are sent.
- R8: At the end of a transaction, `done` pulses for one cycle. In that same cycle, `status_out` takes the resolved status of the last reply, and `err_flag` is set if that reply was in error. `status_out` changes at no other time.
- R9: `err_flag` is sticky until the next accepted `start`, which clears it. A `start` while `busy` is ignored.
- R10: `frm_req` is a one-cycle pulse, and no new request is issued until the engine has answered the previous one with `frm_done`. `frm_is_status` marks status requests.
- R11: After reset, `busy`, `frm_req`, `done` and `err_flag` are 0 and `status_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a write transaction (accepted when idle) |
| cmd_payload | input | 32 | Command payload, captured at start |
| crc_gen_en | input | 1 | Append CRC8 to the command frame |
| crc_chk_en | input | 1 | Verify CRC8 of the status reply |
| vote_en | input | 1 | 2-of-3 vote on the status copies |
| poly_mask | input | 8 | CRC8 tap mask, x^7..x^0 |
| ifd_setting | input | 17 | Command-to-status gap in ticks |
| retry_delay | input | 16 | Gap before a retry, in ticks |
| retry_limit | input | 5 | Maximum number of retries |
| tick_100ns | input | 1 | Coarse timing pulse |
| sclk_tick | input | 1 | One pulse per serial clock period |
| frm_req | output | 1 | Frame request pulse to the engine |
| frm_is_status | output | 1 | Request is a status read |
| frm_tx | output | 32 | Frame to transmit |
| frm_done | input | 1 | Engine finished the requested frame |
| frm_rx | input | 32 | Received frame, valid with frm_done |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished (one cycle) |
| status_out | output | 8 | Resolved status of the last reply |
| err_flag | output | 1 | Sticky error after retries used up |

## Verification
Several properties are checked on every cycle: the frame request handshake (single-cycle pulses, one request outstanding), the retry bound measured against `retry_limit`, the fact that `status_out` and a rising `err_flag` appear only with `done`, the clearing of the error at `start`, and that the command frame carries the captured payload. The bench scenarios are needed for everything that depends on data or time. These cover the CRC value for chosen masks, majority resolution against disagreeing copies, how the error decision depends on the check enable, the number of frames sent under recovering and persistent faults, and the measured lengths of the inter-frame and retry gaps.

// File: rtl/vid_wr_pkg.sv
package vid_wr_pkg;

  localparam int FRAME_W = 32;
  localparam int CRC_W   = 8;
  localparam int BODY_W  = FRAME_W - CRC_W;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD_REQ,
    S_CMD_WAIT,
    S_IFD,
    S_STS_REQ,
    S_STS_WAIT,
    S_RTY
  } vid_state_e;

  // Serial CRC8, MSB first, init 0; x^8 implied, mask bit k enables x^k.
  function automatic logic [CRC_W-1:0] crc8_body(input logic [BODY_W-1:0] body,
                                                 input logic [CRC_W-1:0]  mask);
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = BODY_W-1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ body[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ mask;
    end
    return r;
  endfunction

  function automatic logic [7:0] vote3(input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/vid_delay_timer.sv
module vid_delay_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic             sclk_tick,
  input  logic             tick,
  output logic             expired
);
  logic             active_q;
  logic             sclk_seen_q;
  logic [CNT_W-1:0] remain_q;

  assign expired = active_q && sclk_seen_q && (remain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      sclk_seen_q <= 1'b0;
      remain_q    <= '0;
    end else if (load) begin
      active_q    <= 1'b1;
      sclk_seen_q <= 1'b0;
      remain_q    <= count;
    end else if (active_q) begin
      if (expired)          active_q    <= 1'b0;
      else if (!sclk_seen_q) sclk_seen_q <= sclk_tick;
      else if (tick)        remain_q    <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/vid_status_eval.sv
module vid_status_eval
  import vid_wr_pkg::*;
(
  input  logic [FRAME_W-1:0] rx,
  input  logic               vote_en,
  input  logic               crc_chk_en,
  input  logic [CRC_W-1:0]   poly_mask,
  output logic [7:0]         status,
  output logic               crc_bad
);
  logic [CRC_W-1:0] rx_crc_calc;

  assign rx_crc_calc = crc8_body(rx[FRAME_W-1:CRC_W], poly_mask);
  assign crc_bad     = crc_chk_en && (rx_crc_calc != rx[CRC_W-1:0]);
  assign status      = vote_en ? vote3(rx[31:24], rx[23:16], rx[15:8]) : rx[31:24];
endmodule

// File: rtl/vid_write_ctrl.sv
module vid_write_ctrl
  import vid_wr_pkg::*;
#(
  parameter int IFD_W = 17,
  parameter int RTY_W = 16,
  parameter int LIM_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] cmd_payload,
  input  logic               crc_gen_en,
  input  logic               crc_chk_en,
  input  logic               vote_en,
  input  logic [CRC_W-1:0]   poly_mask,
  input  logic [IFD_W-1:0]   ifd_setting,
  input  logic [RTY_W-1:0]   retry_delay,
  input  logic [LIM_W-1:0]   retry_limit,
  input  logic               tick_100ns,
  input  logic               sclk_tick,
  output logic               frm_req,
  output logic               frm_is_status,
  output logic [FRAME_W-1:0] frm_tx,
  input  logic               frm_done,
  input  logic [FRAME_W-1:0] frm_rx,
  output logic               busy,
  output logic               done,
  output logic [7:0]         status_out,
  output logic               err_flag
);
  localparam int TMR_W = (IFD_W > RTY_W) ? IFD_W : RTY_W;

  vid_state_e         state_q, state_d;
  logic [FRAME_W-1:0] cmd_q;
  logic [LIM_W-1:0]   tries_q;
  logic               done_q, err_q;
  logic [7:0]         status_q;

  // named internal events
  logic               start_ok;
  logic               sts_arrive;
  logic               sts_bad;
  logic               retry_go;
  logic               finish;
  logic               tmr_load;
  logic [TMR_W-1:0]   tmr_count;
  logic               tmr_expired;
  logic [7:0]         sts_resolved;
  logic [FRAME_W-1:0] cmd_frame;

  assign start_ok   = start && (state_q == S_IDLE);
  assign sts_arrive = (state_q == S_STS_WAIT) && frm_done;
  assign retry_go   = sts_arrive && sts_bad && (tries_q != retry_limit);
  assign finish     = sts_arrive && !retry_go;
  assign tmr_load   = ((state_q == S_CMD_WAIT) && frm_done) || retry_go;
  assign tmr_count  = (state_q == S_CMD_WAIT) ? TMR_W'(ifd_setting) : TMR_W'(retry_delay);

  assign cmd_frame = crc_gen_en
                   ? {cmd_q[FRAME_W-1:CRC_W], crc8_body(cmd_q[FRAME_W-1:CRC_W], poly_mask)}
                   : cmd_q;

  vid_status_eval u_eval (
    .rx         (frm_rx),
    .vote_en    (vote_en),
    .crc_chk_en (crc_chk_en),
    .poly_mask  (poly_mask),
    .status     (sts_resolved),
    .crc_bad    (sts_bad)
  );

  vid_delay_timer #(.CNT_W(TMR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tmr_load),
    .count     (tmr_count),
    .sclk_tick (sclk_tick),
    .tick      (tick_100ns),
    .expired   (tmr_expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (start_ok) state_d = S_CMD_REQ;
      S_CMD_REQ:  state_d = S_CMD_WAIT;
      S_CMD_WAIT: if (frm_done) state_d = S_IFD;
      S_IFD:      if (tmr_expired) state_d = S_STS_REQ;
      S_STS_REQ:  state_d = S_STS_WAIT;
      S_STS_WAIT: if (retry_go) state_d = S_RTY;
                  else if (finish) state_d = S_IDLE;
      S_RTY:      if (tmr_expired) state_d = S_CMD_REQ;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cmd_q    <= '0;
      tries_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      status_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (start_ok) begin
        cmd_q   <= cmd_payload;
        tries_q <= '0;
        err_q   <= 1'b0;
      end
      if (retry_go) tries_q <= tries_q + 1'b1;
      if (finish) begin
        status_q <= sts_resolved;
        err_q    <= sts_bad;
      end
    end
  end

  assign frm_req       = (state_q == S_CMD_REQ) || (state_q == S_STS_REQ);
  assign frm_is_status = (state_q == S_STS_REQ);
  assign frm_tx        = frm_is_status ? '0 : cmd_frame;
  assign busy          = (state_q != S_IDLE);
  assign done          = done_q;
  assign status_out    = status_q;
  assign err_flag      = err_q;
endmodule

// File: rtl/vid_write_ctrl_chk.sv
module vid_write_ctrl_chk #(
  parameter int LIM_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             frm_req,
  input logic             frm_is_status,
  input logic             frm_done,
  input logic [31:0]      frm_tx,
  input logic [31:0]      cmd_payload,
  input logic [LIM_W-1:0] retry_limit,
  input logic             done,
  input logic [7:0]       status_out,
  input logic             err_flag
);
  logic           pend_q;
  logic [LIM_W:0] cmd_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      cmd_cnt_q <= '0;
    end else begin
      if (frm_req) pend_q <= 1'b1;
      else if (frm_done) pend_q <= 1'b0;
      if (start && !busy) cmd_cnt_q <= '0;
      else if (frm_req && !frm_is_status) cmd_cnt_q <= cmd_cnt_q + 1'b1;
    end
  end

  p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req |=> !frm_req);
  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req |-> !pend_q);
  p_retry_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_req && !frm_is_status) |-> (cmd_cnt_q <= {1'b0, retry_limit}));
  p_status_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_out) |-> done);
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> done);
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !err_flag);
  p_cmd_body_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_req && !frm_is_status) |-> (frm_tx[31:8] == cmd_payload[31:8]));
endmodule

bind vid_write_ctrl vid_write_ctrl_chk #(.LIM_W(LIM_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .frm_req       (frm_req),
  .frm_is_status (frm_is_status),
  .frm_done      (frm_done),
  .frm_tx        (frm_tx),
  .cmd_payload   (cmd_payload),
  .retry_limit   (retry_limit),
  .done          (done),
  .status_out    (status_out),
  .err_flag      (err_flag)
);

// File: tb/vid_write_ctrl_tb_top.sv
`timescale 1ns/1ps
module vid_write_ctrl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, crc_gen_en = 0, crc_chk_en = 0, vote_en = 0;
  logic [31:0] cmd_payload = 0, frm_rx = 0;
  logic [7:0]  poly_mask = 8'hD5;
  logic [16:0] ifd_setting = 0;
  logic [15:0] retry_delay = 0;
  logic [4:0]  retry_limit = 0;
  logic        tick_100ns = 0, sclk_tick = 0, frm_done = 0;
  logic        frm_req, frm_is_status, busy, done, err_flag;
  logic [31:0] frm_tx;
  logic [7:0]  status_out;

  int tests = 0, fails = 0;
  int cyc = 0, resp_cnt = 0, resp_sts = 0;
  int n_cmd = 0, n_sts = 0, t_cmd_done = 0, t_sts_done = 0, sts_seen = 0;
  int ifd_gap = -1, rty_gap = -1;
  logic [31:0] exp_tx = 0;
  logic [31:0] rxq[$];

  always #10 clk = ~clk; // 50 MHz

  vid_write_ctrl dut_i (.*);

  // Bench-side CRC: long division by {1,mask} over body*2^8.
  function automatic logic [7:0] ref_crc(input logic [23:0] body, input logic [7:0] mask);
    logic [31:0] v;
    logic [8:0]  g;
    v = {body, 8'h00};
    g = {1'b1, mask};
    for (int i = 31; i >= 8; i--)
      if (v[i]) v = v ^ (32'(g) << (i - 8));
    return v[7:0];
  endfunction

  function automatic logic [7:0] ref_vote(input logic [31:0] w);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) begin
      int n;
      n = int'(w[24+b]) + int'(w[16+b]) + int'(w[8+b]);
      r[b] = (n >= 2);
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_sts(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] c, input bit good);
    logic [7:0] k;
    k = ref_crc({a, b, c}, poly_mask);
    return {a, b, c, good ? k : ~k};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // tick generators, engine model and per-clock comparison of command frames
  always @(negedge clk) begin
    cyc++;
    sclk_tick  = (cyc % 8 == 0);
    tick_100ns = (cyc % 5 == 0);
    frm_done   = 0;
    if (resp_cnt > 0) begin
      resp_cnt--;
      if (resp_cnt == 0) begin
        frm_done = 1;
        if (resp_sts != 0) begin
          frm_rx = (rxq.size() > 0) ? rxq.pop_front() : 32'h0;
          t_sts_done = cyc; sts_seen = 1;
        end else begin
          frm_rx = 32'h0; t_cmd_done = cyc;
        end
      end
    end
    if (rst_n && frm_req) begin
      resp_cnt = 3;
      resp_sts = int'(frm_is_status);
      if (frm_is_status) begin
        n_sts++; ifd_gap = cyc - t_cmd_done;
      end else begin
        n_cmd++;
        if (sts_seen != 0) rty_gap = cyc - t_sts_done;
        check("R1/R2 command frame", frm_tx, exp_tx);
      end
    end
  end

  task automatic run(input logic [31:0] pay, input bit gen, input bit chk, input bit vt,
                     input logic [16:0] ifd, input logic [15:0] rty, input logic [4:0] lim);
    int w;
    @(negedge clk);
    cmd_payload = pay; crc_gen_en = gen; crc_chk_en = chk; vote_en = vt;
    ifd_setting = ifd; retry_delay = rty; retry_limit = lim;
    exp_tx = gen ? {pay[31:8], ref_crc(pay[31:8], poly_mask)} : pay;
    n_cmd = 0; n_sts = 0; sts_seen = 0; ifd_gap = -1; rty_gap = -1;
    start = 1;
    @(negedge clk);
    start = 0;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    if (w >= 20000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected done");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 busy", busy, 0); check("R11 req", frm_req, 0);
    check("R11 err", err_flag, 0); check("R11 status", status_out, 0);
    check("R11 done", done, 0);
    rst_n = 1;

    // R1 R3 R4 good reply, voting, crc gen
    rxq.push_back(mk_sts(8'h5A, 8'h5A, 8'h5A, 1));
    run(32'h1234_56FF, 1, 1, 1, 17'd6, 16'd0, 5'd3);
    check("R1 frames", n_cmd, 1); check("R8 status", status_out, 8'h5A);
    check("R4 no err", err_flag, 0);
    check_rng("R5 ifd N=6", ifd_gap, 25, 42);

    // R2 gen off, R3 vote on with disagreeing copies
    rxq.push_back(mk_sts(8'h3C, 8'hA5, 8'hA5, 1));
    run(32'hDEAD_BEEF, 0, 1, 1, 17'd0, 16'd0, 5'd0);
    check("R3 vote", status_out, ref_vote(mk_sts(8'h3C, 8'hA5, 8'hA5, 1)));
    check_rng("R5 ifd N=0", ifd_gap, 1, 12);

    // R3 vote off takes top copy
    rxq.push_back(mk_sts(8'h3C, 8'hA5, 8'hA5, 1));
    run(32'h0000_0001, 1, 1, 0, 17'd1, 16'd0, 5'd0);
    check("R3 no vote", status_out, 8'h3C);

    // R6 R7 one bad then good, limit 3
    poly_mask = 8'h07;
    rxq.push_back(mk_sts(8'h11, 8'h11, 8'h11, 0));
    rxq.push_back(mk_sts(8'h22, 8'h22, 8'h22, 1));
    run(32'hCAFE_0000, 1, 1, 1, 17'd2, 16'd20, 5'd3);
    check("R7 recover frames", n_cmd, 2); check("R7 err", err_flag, 0);
    check("R8 status", status_out, 8'h22);
    check_rng("R6 retry gap N=20", rty_gap, 95, 112);

    // R7 R8 persistent error, limit 2
    poly_mask = 8'hD5;
    repeat (3) rxq.push_back(mk_sts(8'h81, 8'h81, 8'h01, 0));
    run(32'h0F0F_0F0F, 1, 1, 1, 17'd0, 16'd0, 5'd2);
    check("R7 exhausted frames", n_cmd, 3); check("R8 err", err_flag, 1);
    check("R8 last status", status_out, 8'h81);
    repeat (5) @(negedge clk);
    check("R9 sticky", err_flag, 1);
    check("R9 busy idle", busy, 0);

    // R7 limit 0 bad reply
    rxq.push_back(mk_sts(8'h44, 8'h44, 8'h44, 0));
    run(32'h7777_7777, 1, 1, 1, 17'd0, 16'd0, 5'd0);
    check("R7 no retry", n_cmd, 1); check("R8 err", err_flag, 1);

    // R4 check disabled: bad crc accepted; R9 error cleared by start
    rxq.push_back(mk_sts(8'h66, 8'h66, 8'h66, 0));
    run(32'h2468_ACE0, 1, 0, 1, 17'd0, 16'd0, 5'd4);
    check("R4 chk off frames", n_cmd, 1); check("R9 cleared", err_flag, 0);
    check("R4 status", status_out, 8'h66);

    // R9 start while busy ignored
    rxq.push_back(mk_sts(8'h99, 8'h99, 8'h99, 1));
    fork
      run(32'h1357_9BDF, 0, 1, 1, 17'd4, 16'd0, 5'd0);
      begin repeat (6) @(negedge clk); start = 1; @(negedge clk); start = 0; end
    join
    repeat (30) @(negedge clk);
    check("R9 busy start ignored", n_cmd, 1);
    check("R10 sts frames", n_sts, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule